// File: doc/BRIEF.md
# Dual Mode-Configurable Timer/Counter Pair

This block holds two 16-bit timer/counter channels. Each channel is a low byte and a high byte. One shared 8-bit configuration register gives each channel three settings: a gate-enable bit, a source bit and a two-bit operating mode. The source bit picks between counting core clock cycles and counting falling edges on an external event pin. The four modes are a 13-bit counter with a 5-bit prescaler, a 16-bit cascade, an 8-bit counter that reloads itself, and a split mode. In split mode, channel 0 becomes two independent 8-bit counters, and the run input of channel 1 drives the upper one.

Software programs the configuration register and loads or samples the four count bytes over a small synchronous register bus. A run input enables each channel. When a channel's gate bit is set, that channel also needs its external gate pin to be high. The external event and gate pins are asynchronous to the block and are resynchronised inside it. Each channel has a single-cycle overflow flag output.

Top module: `tmr_pair`

## Requirements
- R1: After a synchronous reset, the configuration register and all four count bytes read 0 and both overflow outputs are low.
- R2: Bus address 0 is the configuration register: bit7 gate1, bit6 source1 (1 = event counting), bits[5:4] mode1, bit3 gate0, bit2 source0, bits[1:0] mode0. Addresses 1, 2, 3 and 4 are the channel 0 low byte, channel 0 high byte, channel 1 low byte and channel 1 high byte. A write updates the addressed register on the clock edge. Reads are combinational. Other addresses read 0.
- R3: In mode 00, bits[4:0] of the low byte act as a prescaler and bits[7:5] hold their value. The high byte increments when the prescaler wraps from 31 to 0. The channel overflows when the high byte is 0xFF and the prescaler is 31.
- R4: In mode 01, the high and low bytes form one 16-bit counter that overflows on the step from 0xFFFF to 0x0000.
- R5: In mode 10, the low byte counts. On a step from 0xFF, the low byte loads the high byte instead and the channel overflows. The high byte is not changed.
- R6: In mode 11, channel 0's low byte counts under channel 0's own run, gate and source settings. Channel 0's high byte counts once per clock while channel 1's run input is high, regardless of any gate or source setting. The wrap of that high byte from 0xFF pulses the channel 1 overflow output.
- R7: In mode 11, channel 1 holds both of its bytes and produces no overflow of its own.
- R8: A channel whose gate bit is 0 counts whenever its run input is high. A channel whose gate bit is 1 counts only while its run input is high and its synchronised gate pin is high.
- R9: With source 0, an enabled channel takes exactly one step per clock cycle.
- R10: With source 1, an enabled channel takes one step for each high-to-low transition of its event pin, after two synchronising flops. Levels that last one clock cycle are all counted.
- R11: An overflow output is high for exactly the cycle that follows the clock edge on which the counter wrapped. An overflow output is never high unless the matching run input was high on that edge.
- R12: A bus write to either byte of a channel takes priority over counting. On that edge, the written byte takes the bus data and the channel's other byte holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| run | input | 2 | Per-channel run control |
| ev_in | input | 2 | Per-channel external event pins (asynchronous) |
| gate_in | input | 2 | Per-channel external gate pins (asynchronous) |
| ovf | output | 2 | Per-channel single-cycle overflow flags |

## Verification
Timer counting is driven with random modes 00 to 10 on both channels at once. The start values are placed near the wrap point, and the run lengths are random. This separates the prescaler, cascade and reload paths by their final byte values and by their exact counts of overflow pulses. Event counting is driven by two pulse shapes: one-cycle high and low levels, and longer uneven levels. The first checks the maximum event rate and the second shows that only falling edges count. Directed cases cover the following:
- split mode, with channel 1's run on and off
- gating, with the gate pin held low and then high
- a write that lands while the counter is running, to show the write overrides the step

// File: rtl/tmr_pair_pkg.sv
package tmr_pair_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;
    localparam int PRE_W  = 5;
    localparam int NCH    = 2;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] ADDR_CFG = '0;

    typedef enum logic [1:0] {
        MODE_PRE13  = 2'b00,
        MODE_CAS16  = 2'b01,
        MODE_RELOAD = 2'b10,
        MODE_SPLIT  = 2'b11
    } tmr_mode_e;

    // Field order matches the register nibble: gate at the top, mode at the bottom.
    typedef struct packed {
        logic      gate;
        logic      is_evt;
        tmr_mode_e mode;
    } chan_cfg_t;

    typedef struct packed {
        logic [BYTE_W-1:0] hi;
        logic [BYTE_W-1:0] lo;
    } cnt_pair_t;

    function automatic logic [ADDR_W-1:0] lo_addr(input int ch);
        return ADDR_W'(1 + 2 * ch);
    endfunction

    function automatic logic [ADDR_W-1:0] hi_addr(input int ch);
        return ADDR_W'(2 + 2 * ch);
    endfunction

endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[s] <= '0;
                else     chain[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[s] <= '0;
                else     chain[s] <= chain[s-1];
            end
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/tmr_fall.sv
module tmr_fall #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] fall
);

    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= lvl;
    end

    // A high sample followed by a low sample is one event.
    assign fall = prev_q & ~lvl;

endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
    import tmr_pair_pkg::*;
#(
    parameter bit SPLIT_OK = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  chan_cfg_t         cfg,
    input  logic              step,
    input  logic              split_step,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wdata,
    output cnt_pair_t         cnt,
    output logic              wrap_main,
    output logic              wrap_split
);

    cnt_pair_t cnt_q;
    cnt_pair_t cnt_d;
    logic      hold;

    assign hold = wr_lo | wr_hi;

    always_comb begin
        cnt_d      = cnt_q;
        wrap_main  = 1'b0;
        wrap_split = 1'b0;
        if (!hold) begin
            unique case (cfg.mode)
                MODE_PRE13: begin
                    if (step) begin
                        if (&cnt_q.lo[PRE_W-1:0]) begin
                            cnt_d.lo[PRE_W-1:0] = '0;
                            cnt_d.hi            = cnt_q.hi + BYTE_W'(1);
                            wrap_main           = &cnt_q.hi;
                        end else begin
                            cnt_d.lo[PRE_W-1:0] = cnt_q.lo[PRE_W-1:0] + PRE_W'(1);
                        end
                    end
                end
                MODE_CAS16: begin
                    if (step) begin
                        cnt_d     = cnt_q + CNT_W'(1);
                        wrap_main = &cnt_q;
                    end
                end
                MODE_RELOAD: begin
                    if (step) begin
                        if (&cnt_q.lo) begin
                            cnt_d.lo  = cnt_q.hi;
                            wrap_main = 1'b1;
                        end else begin
                            cnt_d.lo = cnt_q.lo + BYTE_W'(1);
                        end
                    end
                end
                MODE_SPLIT: begin
                    if (SPLIT_OK) begin
                        if (step) begin
                            cnt_d.lo  = cnt_q.lo + BYTE_W'(1);
                            wrap_main = &cnt_q.lo;
                        end
                        if (split_step) begin
                            cnt_d.hi   = cnt_q.hi + BYTE_W'(1);
                            wrap_split = &cnt_q.hi;
                        end
                    end
                end
                default: ;
            endcase
        end
        if (wr_lo) cnt_d.lo = wdata;
        if (wr_hi) cnt_d.hi = wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
    import tmr_pair_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic [NCH-1:0]    run,
    input  logic [NCH-1:0]    ev_in,
    input  logic [NCH-1:0]    gate_in,
    output logic [NCH-1:0]    ovf
);

    chan_cfg_t      cfg_q [NCH];
    cnt_pair_t      cnt_v [NCH];
    logic [NCH-1:0] ev_s, gate_s, ev_fall;
    logic [NCH-1:0] en, step, split_step, wr_lo, wr_hi;
    logic [NCH-1:0] wrap_main, wrap_split;
    logic [NCH-1:0] ovf_d, ovf_q;

    // Configuration register: the channel 1 nibble is above the channel 0 nibble.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < NCH; c++) cfg_q[c] <= '0;
        end else if (bus_we && bus_addr == ADDR_CFG) begin
            {cfg_q[1], cfg_q[0]} <= bus_wdata;
        end
    end

    tmr_sync #(.W(2 * NCH), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({gate_in, ev_in}),
        .q   ({gate_s, ev_s})
    );

    tmr_fall #(.W(NCH)) u_fall (
        .clk  (clk),
        .rst  (rst),
        .lvl  (ev_s),
        .fall (ev_fall)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        assign en[c]         = run[c] & (~cfg_q[c].gate | gate_s[c]);
        assign step[c]       = en[c] & (cfg_q[c].is_evt ? ev_fall[c] : 1'b1);
        assign split_step[c] = (c == 0) ? run[NCH-1] : 1'b0;
        assign wr_lo[c]      = bus_we && (bus_addr == lo_addr(c));
        assign wr_hi[c]      = bus_we && (bus_addr == hi_addr(c));

        tmr_chan #(.SPLIT_OK(c == 0)) u_ch (
            .clk        (clk),
            .rst        (rst),
            .cfg        (cfg_q[c]),
            .step       (step[c]),
            .split_step (split_step[c]),
            .wr_lo      (wr_lo[c]),
            .wr_hi      (wr_hi[c]),
            .wdata      (bus_wdata),
            .cnt        (cnt_v[c]),
            .wrap_main  (wrap_main[c]),
            .wrap_split (wrap_split[c])
        );
    end

    // The split high byte of channel 0 reports on the last channel's flag.
    always_comb begin
        ovf_d          = wrap_main;
        ovf_d[NCH-1]   = wrap_main[NCH-1] | (|wrap_split);
    end

    always_ff @(posedge clk) begin
        if (rst) ovf_q <= '0;
        else     ovf_q <= ovf_d;
    end

    assign ovf = ovf_q;

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_CFG) bus_rdata = {cfg_q[1], cfg_q[0]};
        for (int c = 0; c < NCH; c++) begin
            if (bus_addr == lo_addr(c)) bus_rdata = cnt_v[c].lo;
            if (bus_addr == hi_addr(c)) bus_rdata = cnt_v[c].hi;
        end
    end

endmodule

// File: rtl/tmr_pair_chk.sv
module tmr_pair_chk (
    input logic       clk,
    input logic       rst,
    input logic       bus_we,
    input logic [2:0] bus_addr,
    input logic [7:0] bus_wdata,
    input logic [1:0] run,
    input logic [1:0] ovf,
    input logic [7:0] cfg_byte,
    input logic [7:0] lo0,
    input logic [7:0] hi0,
    input logic [7:0] lo1,
    input logic [7:0] hi1
);

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (ovf == 2'b00 && cfg_byte == 8'h00 && lo0 == 8'h00 &&
                 hi0 == 8'h00 && lo1 == 8'h00 && hi1 == 8'h00));

    assert_cfg_write_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == 3'd0) |=> cfg_byte == $past(bus_wdata));

    assert_cascade_step_R4: assert property (@(posedge clk) disable iff (rst)
        (!bus_we && cfg_byte[3:0] == 4'b0001 && run[0])
        |=> {hi0, lo0} == $past({hi0, lo0}) + 16'd1);

    assert_reload_value_R5: assert property (@(posedge clk) disable iff (rst)
        (!bus_we && cfg_byte[3:0] == 4'b0010 && run[0] && lo0 == 8'hFF)
        |=> lo0 == $past(hi0));

    assert_ch1_frozen_R7: assert property (@(posedge clk) disable iff (rst)
        (!bus_we && cfg_byte[5:4] == 2'b11)
        |=> (lo1 == $past(lo1) && hi1 == $past(hi1)));

    assert_ovf0_needs_run_R11: assert property (@(posedge clk) disable iff (rst)
        ovf[0] |-> $past(run[0]));

    assert_ovf1_needs_run_R11: assert property (@(posedge clk) disable iff (rst)
        ovf[1] |-> $past(run[1]));

    assert_write_wins_lo0_R12: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == 3'd1) |=> (lo0 == $past(bus_wdata) && hi0 == $past(hi0)));

    assert_write_wins_hi1_R12: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == 3'd4) |=> (hi1 == $past(bus_wdata) && lo1 == $past(lo1)));

endmodule

bind tmr_pair tmr_pair_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .run       (run),
    .ovf       (ovf),
    .cfg_byte  ({cfg_q[1], cfg_q[0]}),
    .lo0       (cnt_v[0].lo),
    .hi0       (cnt_v[0].hi),
    .lo1       (cnt_v[1].lo),
    .hi1       (cnt_v[1].hi)
);

// File: tb/sim_tmr_pair.sv
module sim_tmr_pair;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_we = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [1:0] run = '0;
    logic [1:0] ev_in = '0;
    logic [1:0] gate_in = '0;
    logic [1:0] ovf;

    int checks = 0;
    int errors = 0;
    int ovf_n0 = 0;
    int ovf_n1 = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    tmr_pair u0 (
        .clk       (clk),
        .rst       (rst),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .run       (run),
        .ev_in     (ev_in),
        .gate_in   (gate_in),
        .ovf       (ovf)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (ovf[0]) ovf_n0++;
            if (ovf[1]) ovf_n1++;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic run_for(input logic [1:0] mask, input int n);
        @(negedge clk);
        run = mask;
        repeat (n) @(negedge clk);
        run = 2'b00;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic load(input logic [7:0] cfg, input logic [7:0] l0, input logic [7:0] h0,
                        input logic [7:0] l1, input logic [7:0] h1);
        wr(3'd0, cfg); wr(3'd1, l0); wr(3'd2, h0); wr(3'd3, l1); wr(3'd4, h1);
        idle(1);
        #1; ovf_n0 = 0; ovf_n1 = 0;
    endtask

    // Expected behaviour of one timer channel for modes 00, 01, 10.
    function automatic void ref_run(input logic [1:0] m, inout logic [7:0] lo,
                                    inout logic [7:0] hi, input int n, output int nov);
        nov = 0;
        for (int i = 0; i < n; i++) begin
            case (m)
                2'b00: begin
                    if (lo[4:0] == 5'h1F) begin
                        lo[4:0] = 5'h00;
                        if (hi == 8'hFF) nov++;
                        hi = hi + 8'd1;
                    end else lo[4:0] = lo[4:0] + 5'd1;
                end
                2'b01: begin
                    if ({hi, lo} == 16'hFFFF) nov++;
                    {hi, lo} = {hi, lo} + 16'd1;
                end
                default: begin
                    if (lo == 8'hFF) begin lo = hi; nov++; end
                    else lo = lo + 8'd1;
                end
            endcase
        end
    endfunction

    task automatic pulses(input int ch, input int hi_n, input int lo_n, input int k);
        for (int i = 0; i < k; i++) begin
            ev_in[ch] = 1'b1; repeat (hi_n) @(negedge clk);
            ev_in[ch] = 1'b0; repeat (lo_n) @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v, el0, eh0, el1, eh1;
        int e0, e1;
        int unused_seed;
        unused_seed = $urandom(32'h5EED);

        idle(3);
        @(negedge clk); rst = 1'b0;
        idle(1);

        // R1: reset state
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), v); chk("R1 reg after reset", v, 0);
        end
        chk("R1 ovf after reset", ovf, 0);

        // R2: configuration readback and unmapped address
        wr(3'd0, 8'hA5); rd(3'd0, v); chk("R2 cfg readback", v, 8'hA5);
        rd(3'd6, v); chk("R2 unmapped read", v, 0);

        // R3: prescaler wrap into a full high byte
        load(8'h00, 8'hFE, 8'hFF, 8'h00, 8'h00);
        run_for(2'b01, 2); idle(1);
        rd(3'd1, v); chk("R3 lo after prescale wrap", v, 8'hE0);
        rd(3'd2, v); chk("R3 hi after prescale wrap", v, 8'h00);
        chk("R3 ovf count", ovf_n0, 1);

        // R11: pulse width at a 16-bit wrap
        load(8'h01, 8'hFE, 8'hFF, 8'h00, 8'h00);
        run_for(2'b01, 1); chk("R11 no ovf before wrap", ovf[0], 0);
        run_for(2'b01, 1); chk("R11 ovf in cycle after wrap", ovf[0], 1);
        @(negedge clk); chk("R11 ovf lasts one cycle", ovf[0], 0);
        rd(3'd2, v); chk("R4 16-bit wrap hi", v, 0);

        // R5: reload
        load(8'h02, 8'hFE, 8'h80, 8'h00, 8'h00);
        run_for(2'b01, 3); idle(1);
        rd(3'd1, v); chk("R5 lo after reload", v, 8'h81);
        rd(3'd2, v); chk("R5 hi untouched", v, 8'h80);
        chk("R5 ovf count", ovf_n0, 1);

        // R6 / R7: split mode with channel 1 run on
        load(8'h33, 8'hFE, 8'hFD, 8'h12, 8'h34);
        run_for(2'b11, 4); idle(1);
        rd(3'd1, v); chk("R6 split lo", v, 8'h02);
        rd(3'd2, v); chk("R6 split hi", v, 8'h01);
        chk("R6 ovf0 from lo", ovf_n0, 1);
        chk("R6 ovf1 from split hi", ovf_n1, 1);
        rd(3'd3, v); chk("R7 ch1 lo held", v, 8'h12);
        rd(3'd4, v); chk("R7 ch1 hi held", v, 8'h34);
        // split high byte idle without channel 1 run
        load(8'h33, 8'h10, 8'h20, 8'h12, 8'h34);
        run_for(2'b01, 5); idle(1);
        rd(3'd1, v); chk("R6 split lo own run", v, 8'h15);
        rd(3'd2, v); chk("R6 split hi needs run1", v, 8'h20);
        run_for(2'b10, 3); idle(1);
        rd(3'd2, v); chk("R6 split hi with run1", v, 8'h23);
        rd(3'd3, v); chk("R7 ch1 lo still held", v, 8'h12);

        // R8: gating
        load(8'h09, 8'h00, 8'h00, 8'h00, 8'h00);
        gate_in = 2'b00;
        run_for(2'b01, 10); idle(1);
        rd(3'd1, v); chk("R8 gate low blocks", v, 0);
        gate_in = 2'b01; idle(4);
        run_for(2'b01, 10); idle(1);
        rd(3'd1, v); chk("R8 gate high runs", v, 10);
        idle(4);
        rd(3'd1, v); chk("R8 run low with gate high", v, 10);
        gate_in = 2'b00;

        // R10: event counting on channel 0, then channel 1
        load(8'h05, 8'h00, 8'h00, 8'h00, 8'h00);
        @(negedge clk); run = 2'b01;
        pulses(0, 1, 1, 7);
        idle(5);
        rd(3'd1, v); chk("R10 one-cycle levels", v, 7);
        pulses(0, 3, 2, 4);
        idle(5);
        run = 2'b00;
        rd(3'd1, v); chk("R10 uneven levels", v, 11);
        pulses(0, 1, 1, 3); idle(5);
        rd(3'd1, v); chk("R10 events ignored when stopped", v, 11);
        load(8'h50, 8'h00, 8'h00, 8'h00, 8'h00);
        @(negedge clk); run = 2'b10;
        pulses(1, 2, 1, 5); idle(5);
        run = 2'b00;
        rd(3'd3, v); chk("R10 ch1 events", v, 5);

        // R12: write during counting
        load(8'h01, 8'h10, 8'h22, 8'h00, 8'h00);
        @(negedge clk); run = 2'b01;
        idle(3);
        bus_we = 1'b1; bus_addr = 3'd1; bus_wdata = 8'h40;
        @(negedge clk); bus_we = 1'b0;
        rd(3'd1, v); chk("R12 write beats step lo", v, 8'h40);
        rd(3'd2, v); chk("R12 other byte holds", v, 8'h22);
        @(negedge clk);
        rd(3'd1, v); chk("R12 counting resumes", v, 8'h41);
        run = 2'b00;

        // R9 / R3 / R4 / R5 / R11: random timer runs on both channels
        for (int it = 0; it < 24; it++) begin
            logic [1:0] m0, m1;
            int n;
            m0 = 2'($urandom % 3); m1 = 2'($urandom % 3);
            el0 = 8'($urandom); eh0 = 8'hFF - 8'($urandom % 4);
            el1 = 8'($urandom); eh1 = 8'hFF - 8'($urandom % 4);
            n = 1 + int'($urandom % 300);
            load({2'b00, m1, 2'b00, m0}, el0, eh0, el1, eh1);
            run_for(2'b11, n); idle(1);
            ref_run(m0, el0, eh0, n, e0);
            ref_run(m1, el1, eh1, n, e1);
            rd(3'd1, v); chk("R9 random ch0 lo", v, el0);
            rd(3'd2, v); chk("R9 random ch0 hi", v, eh0);
            rd(3'd3, v); chk("R9 random ch1 lo", v, el1);
            rd(3'd4, v); chk("R9 random ch1 hi", v, eh1);
            chk("R11 random ch0 ovf count", ovf_n0, e0);
            chk("R11 random ch1 ovf count", ovf_n1, e1);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule